// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Engine

This block is the device side of an Ultra DMA data-in burst. It takes 16-bit words from an internal FIFO and sends them to the host. The host receives each word on a toggle of a source-synchronous strobe, and the strobe changes state exactly once per word. The spacing between data edges is never shorter than the minimum cycle time of the selected mode, expressed in clock counts. The host can hold the burst off with its ready line and can end it with its halt line. The device can also end the burst itself. At the end of a burst the strobe is always left high.

Each word that is sent is folded into a 16-bit CRC. After the burst ends, the host returns its own CRC value. A difference between the two raises an interface CRC error flag, and that flag stays set until the next burst starts. The timing counts (minimum cycle, strobe park limit, ready-to-halt gap, halt acknowledge) come from a per-mode table of clock counts.

The state machine has six states:
- IDLE: no burst is active.
- XFER: words are being sent.
- DEV_WAIT: the device has ended the burst and is waiting out the ready-to-halt gap.
- PARK: the strobe is driven high.
- CRC: waiting for the host's CRC value.
- HOLD: counting the acknowledge time.

Its transitions are:
- start accepted: IDLE to XFER.
- host halt: XFER or DEV_WAIT to PARK.
- device end: XFER to DEV_WAIT.
- gap expired: DEV_WAIT to PARK.
- park done: PARK to CRC, unconditionally.
- host CRC valid: CRC to HOLD.
- acknowledge expired: HOLD to IDLE, with a one-cycle done pulse.

Top module: `uburst_in_eng`

## Requirements
- R1: A start is accepted only when mode_code is 8'h40 plus n, with n from 0 to 4. Any other code is ignored: busy stays 0 and nothing is popped. This includes the multiword codes 8'h20 to 8'h22 and the codes 8'h3F and 8'h45.
- R2: Each data edge carries one word.
  - When a burst starts, bus_strobe is 1 and the first word goes out on a falling edge.
  - Every strobe toggle during transfer pops one FIFO word, and that word appears on bus_data with the toggle.
  - Successive data edges are at least tCYC clocks apart. The default tCYC for modes 0 to 4 is 23, 15, 11, 8 and 5 clocks.
- R3: While host_rdy is 0, no strobe edge is generated and no word is popped. The transfer resumes when host_rdy returns to 1.
- R4: While fifo_empty is 1, fifo_pop stays 0 and the burst stays open, waiting.
- R5: After host_halt is seen, no further word is sent. The strobe is high within tLI clocks, which defaults to 30, 30, 30, 20 and 20 for modes 0 to 4.
- R6: After a one-cycle dev_end, the engine stops sending and waits tRP clocks before parking. tRP defaults to 32, 25, 20, 20 and 20. If the strobe was low, it rises at the (tRP+3)th clock edge, counting the edge that samples dev_end as the first.
- R7: The CRC covers every word sent.
  - The polynomial is x^16+x^12+x^5+1 (16'h1021). The seed is 16'h4ABA at burst start.
  - Each word is processed bit 15 first.
  - When host_crc_vld is 1, crc_err becomes 1 if host_crc differs from the computed CRC and 0 if it matches.
  - crc_err is cleared when the next burst is accepted and is otherwise stable.
- R8: done pulses for exactly one cycle, at the (tACK+2)th clock edge after the edge that samples host_crc_vld, with that edge counted as the first. tACK defaults to 4. busy drops together with done.
- R9: After reset, busy, done, crc_err and fifo_pop are 0 and bus_strobe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a burst |
| mode_code | input | 8 | Transfer mode code for the burst |
| fifo_data | input | 16 | Word at the FIFO head |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_pop | output | 1 | Take the FIFO head word |
| dev_end | input | 1 | Device-side request to end the burst |
| host_rdy | input | 1 | Host ready to receive |
| host_halt | input | 1 | Host request to end the burst |
| host_crc | input | 16 | CRC value returned by the host |
| host_crc_vld | input | 1 | host_crc is valid |
| bus_data | output | 16 | Word driven to the host |
| bus_strobe | output | 1 | Data strobe, one toggle per word |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle burst completion pulse |
| crc_err | output | 1 | Interface CRC error flag |

## Verification
The hardest situations to reach are parking a strobe that was left low after an odd word count, and a pause that falls in the middle of the gap between two edges. The stimulus table sets the word count and the word index at which a pause starts, so both strobe levels are present when the burst ends. Both kinds of end are used, and each is paired with both a good and a corrupted CRC reply. A monitor follows every pop. It checks the data and the edge spacing against the mode's minimum, and it keeps its own running CRC.

// File: rtl/uburst_pkg.sv
package uburst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_DEV_WAIT,
        ST_PARK,
        ST_CRC,
        ST_HOLD
    } burst_st_t;

    localparam logic [7:0] UMODE_BASE = 8'h40;
    localparam int         UMODE_NUM  = 5;

    function automatic logic code_ok(input logic [7:0] c);
        return (c >= UMODE_BASE) && (c < UMODE_BASE + 8'(UMODE_NUM));
    endfunction

    function automatic logic [2:0] code_idx(input logic [7:0] c);
        return 3'(c - UMODE_BASE);
    endfunction

endpackage

// File: rtl/uburst_timing.sv
module uburst_timing #(
    parameter int NMODE = 5,
    parameter int CW    = 8,
    parameter logic [NMODE-1:0][CW-1:0] CYC_TBL = {8'd5,  8'd8,  8'd11, 8'd15, 8'd23},
    parameter logic [NMODE-1:0][CW-1:0] LI_TBL  = {8'd20, 8'd20, 8'd30, 8'd30, 8'd30},
    parameter logic [NMODE-1:0][CW-1:0] RP_TBL  = {8'd20, 8'd20, 8'd20, 8'd25, 8'd32},
    parameter logic [NMODE-1:0][CW-1:0] ACK_TBL = {8'd4,  8'd4,  8'd4,  8'd4,  8'd4}
) (
    input  logic [2:0]    mode_idx,
    output logic [CW-1:0] t_cyc,
    output logic [CW-1:0] t_li,
    output logic [CW-1:0] t_rp,
    output logic [CW-1:0] t_ack
);
    always_comb begin
        t_cyc = CYC_TBL[0];
        t_li  = LI_TBL[0];
        t_rp  = RP_TBL[0];
        t_ack = ACK_TBL[0];
        for (int i = 0; i < NMODE; i++) begin
            if (mode_idx == 3'(i)) begin
                t_cyc = CYC_TBL[i];
                t_li  = LI_TBL[i];
                t_rp  = RP_TBL[i];
                t_ack = ACK_TBL[i];
            end
        end
    end
endmodule

// File: rtl/uburst_crc16.sv
module uburst_crc16 #(
    parameter int          DW    = 16,
    parameter int          CRCW  = 16,
    parameter logic [CRCW-1:0] POLY = 16'h1021,
    parameter logic [CRCW-1:0] SEED = 16'h4ABA
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            en,
    input  logic [DW-1:0]   word,
    output logic [CRCW-1:0] crc
);
    function automatic logic [CRCW-1:0] fold(input logic [CRCW-1:0] c_in,
                                             input logic [DW-1:0]   d);
        logic [CRCW-1:0] c;
        logic            fb;
        c = c_in;
        for (int i = DW - 1; i >= 0; i--) begin
            fb = c[CRCW-1] ^ d[i];
            c  = {c[CRCW-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        return c;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc <= SEED;
        else if (init) crc <= SEED;
        else if (en)   crc <= fold(crc, word);
    end
endmodule

// File: rtl/uburst_in_eng.sv
module uburst_in_eng
    import uburst_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CRCW = 16,
    parameter int CW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      mode_code,
    input  logic [DW-1:0]   fifo_data,
    input  logic            fifo_empty,
    output logic            fifo_pop,
    input  logic            dev_end,
    input  logic            host_rdy,
    input  logic            host_halt,
    input  logic [CRCW-1:0] host_crc,
    input  logic            host_crc_vld,
    output logic [DW-1:0]   bus_data,
    output logic            bus_strobe,
    output logic            busy,
    output logic            done,
    output logic            crc_err
);
    burst_st_t       st_q, st_d;
    logic [2:0]      midx_q;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   t_cyc, t_li, t_rp, t_ack;
    logic [CRCW-1:0] crc_now;
    logic            start_ok, send;

    assign start_ok = (st_q == ST_IDLE) && start && code_ok(mode_code);
    assign send     = (st_q == ST_XFER) && !host_halt && !dev_end &&
                      (cnt_q == '0) && host_rdy && !fifo_empty;
    assign fifo_pop = send;
    assign busy     = (st_q != ST_IDLE);

    uburst_timing #(.CW(CW)) u_timing (
        .mode_idx (midx_q),
        .t_cyc    (t_cyc),
        .t_li     (t_li),
        .t_rp     (t_rp),
        .t_ack    (t_ack)
    );

    uburst_crc16 #(.DW(DW), .CRCW(CRCW)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (start_ok),
        .en    (send),
        .word  (fifo_data),
        .crc   (crc_now)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (start_ok) st_d = ST_XFER;
            ST_XFER: begin
                if (host_halt)    st_d = ST_PARK;
                else if (dev_end) st_d = ST_DEV_WAIT;
            end
            ST_DEV_WAIT: if (host_halt || cnt_q == '0) st_d = ST_PARK;
            ST_PARK:     st_d = ST_CRC;
            ST_CRC:      if (host_crc_vld) st_d = ST_HOLD;
            ST_HOLD:     if (cnt_q == '0) st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            midx_q     <= '0;
            cnt_q      <= '0;
            bus_strobe <= 1'b1;
            bus_data   <= '0;
            done       <= 1'b0;
            crc_err    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        midx_q     <= code_idx(mode_code);
                        cnt_q      <= '0;
                        bus_strobe <= 1'b1;
                        crc_err    <= 1'b0;
                    end
                end
                ST_XFER: begin
                    if (host_halt) begin
                        cnt_q <= '0;
                    end else if (dev_end) begin
                        cnt_q <= t_rp;
                    end else if (send) begin
                        bus_data   <= fifo_data;
                        bus_strobe <= ~bus_strobe;
                        cnt_q      <= t_cyc - CW'(1);
                    end else if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                ST_DEV_WAIT: if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
                ST_PARK:     bus_strobe <= 1'b1;
                ST_CRC: begin
                    if (host_crc_vld) begin
                        crc_err <= (host_crc != crc_now);
                        cnt_q   <= t_ack;
                    end
                end
                ST_HOLD: begin
                    if (cnt_q == '0) done  <= 1'b1;
                    else             cnt_q <= cnt_q - CW'(1);
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // checker state: cycles since the last data edge, cycles the strobe is left low after halt
    logic [CW-1:0] gap_q, li_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            li_q   <= '0;
        end else begin
            if (st_q == ST_IDLE) seen_q <= 1'b0;
            if (send) begin
                gap_q  <= CW'(1);
                seen_q <= 1'b1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + CW'(1);
            end
            if (busy && host_halt && !bus_strobe) li_q <= li_q + CW'(1);
            else                                  li_q <= '0;
        end
    end

    a_r1_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !code_ok(mode_code)) |=> !busy);

    a_r2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && seen_q) |-> (gap_q >= t_cyc));

    a_r3_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XFER && !host_rdy) |=> $stable(bus_strobe));

    a_r4_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_pop);

    a_r5_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CRC) |-> bus_strobe);

    a_r5_li_limit: assert property (@(posedge clk) disable iff (!rst_n)
        li_q <= t_li);

    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q inside {ST_XFER, ST_DEV_WAIT, ST_PARK, ST_HOLD}) |=> $stable(crc_err));

    a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/tb_uburst_in_eng.sv
`timescale 1ns/1ps
module tb_uburst_in_eng;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  mode_code = 8'h00;
    logic [15:0] fifo_data;
    logic        fifo_empty;
    logic        fifo_pop;
    logic        dev_end = 1'b0;
    logic        host_rdy = 1'b1;
    logic        host_halt = 1'b0;
    logic [15:0] host_crc = 16'h0;
    logic        host_crc_vld = 1'b0;
    logic [15:0] bus_data;
    logic        bus_strobe;
    logic        busy, done, crc_err;

    always #2.5 clk = ~clk;

    uburst_in_eng dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_code(mode_code),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .dev_end(dev_end), .host_rdy(host_rdy), .host_halt(host_halt),
        .host_crc(host_crc), .host_crc_vld(host_crc_vld),
        .bus_data(bus_data), .bus_strobe(bus_strobe),
        .busy(busy), .done(done), .crc_err(crc_err)
    );

    localparam int CYC_T[5] = '{23, 15, 11, 8, 5};
    localparam int LI_T[5]  = '{30, 30, 30, 20, 20};
    localparam int RP_T[5]  = '{32, 25, 20, 20, 20};
    localparam int ACK_T    = 4;

    typedef struct packed {
        logic [7:0] code;
        logic [7:0] nwords;
        logic [7:0] pause_at;
        logic       host_end;
        logic       bad_crc;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS[NVEC] = '{
        '{8'h40, 8'd7, 8'd3, 1'b1, 1'b0},
        '{8'h44, 8'd8, 8'd2, 1'b0, 1'b1},
        '{8'h42, 8'd5, 8'd1, 1'b1, 1'b1},
        '{8'h43, 8'd6, 8'd0, 1'b0, 1'b0},
        '{8'h41, 8'd9, 8'd4, 1'b0, 1'b0},
        '{8'h44, 8'd3, 8'd1, 1'b1, 1'b0}
    };

    int total = 0;
    int bad = 0;
    int idx = 0;
    int avail = 0;
    int salt = 0;
    int mode_i = 0;
    int cyc_no = 0;
    int last_edge = 0;
    bit have_edge = 1'b0;
    bit pop_pend = 1'b0;
    logic strobe_prev = 1'b1;
    logic [15:0] crc_m = 16'h4ABA;

    function automatic logic [15:0] wv(input int i, input int s);
        return 16'((i * 16'h3B5D) ^ (s * 16'h1111) ^ 16'hC0DE);
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [15:0] d);
        logic [15:0] c;
        logic fb;
        c = c_in;
        for (int i = 15; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    assign fifo_empty = (idx >= avail);
    assign fifo_data  = wv(idx, salt);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: every pop must show up as one strobe toggle carrying the word
    always @(negedge clk) begin
        #1;
        cyc_no++;
        if (pop_pend) begin
            chk(bus_strobe != strobe_prev, "R2", "strobe toggle per word", bus_strobe, !strobe_prev);
            chk(bus_data == wv(idx, salt), "R2", "word on bus", bus_data, wv(idx, salt));
            if (have_edge)
                chk(cyc_no - last_edge >= CYC_T[mode_i], "R2", "edge spacing",
                    cyc_no - last_edge, CYC_T[mode_i]);
            last_edge = cyc_no;
            have_edge = 1'b1;
            crc_m = crc_step(crc_m, bus_data);
            idx++;
        end
        strobe_prev = bus_strobe;
        pop_pend = fifo_pop;
        if (cyc_no > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc_no, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_burst(input vec_t v);
        int k;
        bit odd;
        mode_i = int'(v.code) - 'h40;
        salt++;
        idx = 0;
        avail = int'(v.nwords);
        crc_m = 16'h4ABA;
        have_edge = 1'b0;
        @(negedge clk);
        mode_code = v.code;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1", "valid code accepted", busy, 1);
        chk(crc_err == 1'b0, "R7", "err cleared at start", crc_err, 0);
        if (v.pause_at != 0) begin
            while (idx < int'(v.pause_at)) @(negedge clk);
            @(negedge clk);
            host_rdy = 1'b0;
            begin
                int i0;
                logic s0;
                i0 = idx;
                s0 = bus_strobe;
                clk_n(3 * CYC_T[mode_i]);
                chk(idx == i0, "R3", "no pop while paused", idx, i0);
                chk(bus_strobe == s0, "R3", "strobe held while paused", bus_strobe, s0);
            end
            host_rdy = 1'b1;
        end
        while (idx < int'(v.nwords)) @(negedge clk);
        clk_n(2 * CYC_T[mode_i] + 2);
        chk(idx == int'(v.nwords), "R4", "no pop from empty FIFO", idx, v.nwords);
        chk(busy == 1'b1, "R4", "burst open while empty", busy, 1);
        odd = (bus_strobe == 1'b0);
        if (v.host_end) begin
            host_rdy = 1'b0;
            clk_n(RP_T[mode_i]);
            host_halt = 1'b1;
            k = 0;
            do begin
                clk_n(1);
                k++;
            end while (!bus_strobe && k < 100);
            chk(k <= LI_T[mode_i], "R5", "strobe high within tLI", k, LI_T[mode_i]);
            if (odd) chk(k == 2, "R5", "park edge after halt", k, 2);
            clk_n(4);
            chk(idx == int'(v.nwords), "R5", "no word after halt", idx, v.nwords);
        end else begin
            dev_end = 1'b1;
            clk_n(1);
            dev_end = 1'b0;
            k = 1;
            while (!bus_strobe && k < 200) begin
                clk_n(1);
                k++;
            end
            if (odd) chk(k == RP_T[mode_i] + 3, "R6", "park after tRP", k, RP_T[mode_i] + 3);
            clk_n(RP_T[mode_i] + 4);
            host_halt = 1'b1;
            chk(idx == int'(v.nwords), "R6", "no word after device end", idx, v.nwords);
            chk(bus_strobe == 1'b1, "R6", "strobe parked high", bus_strobe, 1);
        end
        host_crc = crc_m ^ (v.bad_crc ? 16'h0100 : 16'h0000);
        host_crc_vld = 1'b1;
        k = 0;
        do begin
            clk_n(1);
            host_crc_vld = 1'b0;
            k++;
        end while (!done && k < 100);
        chk(k == ACK_T + 2, "R8", "done after tACK", k, ACK_T + 2);
        chk(crc_err == v.bad_crc, "R7", "crc compare", crc_err, v.bad_crc);
        clk_n(1);
        chk(done == 1'b0, "R8", "done one cycle", done, 0);
        chk(busy == 1'b0, "R8", "idle after done", busy, 0);
        host_halt = 1'b0;
        host_rdy = 1'b1;
        clk_n(3);
    endtask

    task automatic try_bad_code(input logic [7:0] c);
        idx = 0;
        avail = 4;
        @(negedge clk);
        mode_code = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        clk_n(10);
        chk(busy == 1'b0, "R1", "bad code ignored", busy, 0);
        chk(idx == 0, "R1", "bad code pops nothing", idx, 0);
        avail = 0;
    endtask

    initial begin
        clk_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9", "busy at reset", busy, 0);
        chk(done == 1'b0, "R9", "done at reset", done, 0);
        chk(crc_err == 1'b0, "R9", "err at reset", crc_err, 0);
        chk(fifo_pop == 1'b0, "R9", "pop at reset", fifo_pop, 0);
        chk(bus_strobe == 1'b1, "R9", "strobe at reset", bus_strobe, 1);

        for (int n = 0; n < NVEC; n++) run_burst(VECS[n]);

        try_bad_code(8'h21);
        try_bad_code(8'h45);
        try_bad_code(8'h3F);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule